// File: doc/BRIEF.md
# Multifunction Integer ALU

This block is a purely combinational integer arithmetic and logic unit. It takes two operands and a 4-bit operation code and returns one result word together with a zero flag and a signed overflow flag. Inside it are a shared adder/subtractor, a four-way bitwise logic unit and a signed set-less-than path. A final selector picks which of these drives the result.

Subtraction runs through the same adder: operand B is inverted and the carry-in is set to one. The signed less-than answer is taken from the difference's sign bit, corrected by the overflow flag, so the block needs no separate magnitude comparator. A datapath that decides equality branches subtracts the two operands and then looks at the zero flag.

Shifts and rotates are handled by a neighbouring block. There is no clock and no state.

Top module: `mfalu_core`

## Requirements
- R1: Operation code 4'b0000 (add) gives result = A + B modulo 2^WIDTH. Overflow is set exactly when A and B have the same sign and the result's sign differs from it.
- R2: Operation code 4'b0010 (subtract) gives result = A - B modulo 2^WIDTH. Overflow is set exactly when the true signed difference lies outside the signed WIDTH-bit range.
- R3: The logic operation codes are 4'b0100 (AND), 4'b0101 (OR), 4'b0110 (XOR) and 4'b0111 (NOR). Each gives the matching bitwise function of A and B, with overflow at 0.
- R4: Operation code 4'b1010 (signed set-less-than) gives result 1 when A < B as two's-complement numbers and 0 otherwise. Bits WIDTH-1 down to 1 of the result are always 0.
- R5: For every defined operation code, the zero flag is 1 exactly when all result bits are 0.
- R6: For signed set-less-than, the overflow flag shows the signed overflow of the subtraction A - B. The result bit equals that difference's sign bit XOR the overflow flag, and this holds at both extremes of the signed range.
- R7: Every other operation code gives result 0, with the zero flag at 0 and the overflow flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (A) |
| op_b | input | WIDTH | Second operand (B) |
| op_code | input | 4 | Operation select |
| result | output | WIDTH | Selected result |
| zero | output | 1 | All result bits zero (defined operations only) |
| ovf | output | 1 | Signed overflow of add, subtract or set-less-than |

## Verification
Every output of this block is due in the same cycle as its stimulus, zero clock edges later, because no register lies between the operands and the flags. The bench changes operands and operation code only on a falling clock edge. It then waits a short settling delay inside the same half cycle and compares result, zero and overflow against its own signed reference model before the next rising edge. Nothing is carried over between vectors, so each check depends only on the inputs applied just before it.

// File: rtl/mfalu_pkg.sv
package mfalu_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_ADD = 4'b0000;
   localparam logic [OPC_W-1:0] OPC_SUB = 4'b0010;
   localparam logic [OPC_W-1:0] OPC_AND = 4'b0100;
   localparam logic [OPC_W-1:0] OPC_OR  = 4'b0101;
   localparam logic [OPC_W-1:0] OPC_XOR = 4'b0110;
   localparam logic [OPC_W-1:0] OPC_NOR = 4'b0111;
   localparam logic [OPC_W-1:0] OPC_SLT = 4'b1010;

   // bitwise unit sub-select codes
   localparam logic [1:0] BW_AND = 2'b00;
   localparam logic [1:0] BW_OR  = 2'b01;
   localparam logic [1:0] BW_NOR = 2'b10;
   localparam logic [1:0] BW_XOR = 2'b11;

   typedef enum logic [1:0] {
      PICK_NONE  = 2'b00,
      PICK_SUM   = 2'b01,
      PICK_BITS  = 2'b10,
      PICK_LESS  = 2'b11
   } pick_t;

   function automatic logic opc_known(input logic [OPC_W-1:0] c);
      return (c == OPC_ADD) || (c == OPC_SUB) || (c == OPC_AND) ||
             (c == OPC_OR)  || (c == OPC_XOR) || (c == OPC_NOR) ||
             (c == OPC_SLT);
   endfunction

endpackage

// File: rtl/mfalu_decode.sv
module mfalu_decode
   import mfalu_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output logic             negate_b,
   output logic [1:0]       bw_sel,
   output pick_t            pick,
   output logic             arith
);

   always_comb begin
      negate_b = 1'b0;
      bw_sel   = BW_AND;
      pick     = PICK_NONE;
      arith    = 1'b0;
      case (opc)
         OPC_ADD: begin
            pick  = PICK_SUM;
            arith = 1'b1;
         end
         OPC_SUB: begin
            negate_b = 1'b1;
            pick     = PICK_SUM;
            arith    = 1'b1;
         end
         OPC_SLT: begin
            negate_b = 1'b1;
            pick     = PICK_LESS;
            arith    = 1'b1;
         end
         OPC_AND: begin
            bw_sel = BW_AND;
            pick   = PICK_BITS;
         end
         OPC_OR: begin
            bw_sel = BW_OR;
            pick   = PICK_BITS;
         end
         OPC_XOR: begin
            bw_sel = BW_XOR;
            pick   = PICK_BITS;
         end
         OPC_NOR: begin
            bw_sel = BW_NOR;
            pick   = PICK_BITS;
         end
         default: begin
            pick = PICK_NONE;
         end
      endcase
   end

endmodule

// File: rtl/mfalu_addsub.sv
module mfalu_addsub #(
   parameter int WIDTH      = 32,
   parameter int RIPPLE_ADD = 0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             negate_b,
   output logic [WIDTH-1:0] sum,
   output logic             sovf
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_in;

   assign b_in = b ^ {WIDTH{negate_b}};

   generate
      if (RIPPLE_ADD != 0) begin : g_ripple
         logic [WIDTH-1:0] cy;
         assign cy[0] = negate_b;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_in[i] ^ cy[i];
            if (i < WIDTH - 1) begin : g_carry
               assign cy[i+1] = (a[i] & b_in[i]) | (cy[i] & (a[i] ^ b_in[i]));
            end
         end
      end else begin : g_flat
         assign sum = a + b_in + {{(WIDTH-1){1'b0}}, negate_b};
      end
   endgenerate

   // both adder inputs agree in sign, sum sign differs
   assign sovf = (a[MSB] == b_in[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/mfalu_bitwise.sv
module mfalu_bitwise
   import mfalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      case (sel)
         BW_AND:  y = a & b;
         BW_OR:   y = a | b;
         BW_NOR:  y = ~(a | b);
         default: y = a ^ b;
      endcase
   end

endmodule

// File: rtl/mfalu_core.sv
module mfalu_core
   import mfalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int RIPPLE_ADD = 0
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       op_code,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mfalu_core: WIDTH must be at least 2");
      end
      if ((RIPPLE_ADD != 0) && (RIPPLE_ADD != 1)) begin : g_bad_style
         $error("mfalu_core: RIPPLE_ADD must be 0 or 1");
      end
      if (OPC_W != 4) begin : g_bad_opc
         $error("mfalu_core: operation code must be 4 bits");
      end
   endgenerate

   logic             negate_b;
   logic [1:0]       bw_sel;
   pick_t            pick;
   logic             arith;
   logic [WIDTH-1:0] sum;
   logic             sovf;
   logic [WIDTH-1:0] bits;
   logic             less;

   mfalu_decode u_dec (
      .opc      (op_code),
      .negate_b (negate_b),
      .bw_sel   (bw_sel),
      .pick     (pick),
      .arith    (arith)
   );

   mfalu_addsub #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_add (
      .a        (op_a),
      .b        (op_b),
      .negate_b (negate_b),
      .sum      (sum),
      .sovf     (sovf)
   );

   mfalu_bitwise #(.WIDTH(WIDTH)) u_bw (
      .a   (op_a),
      .b   (op_b),
      .sel (bw_sel),
      .y   (bits)
   );

   // signed less-than: sign of difference corrected by overflow
   assign less = sum[MSB] ^ sovf;

   always_comb begin
      case (pick)
         PICK_SUM:  result = sum;
         PICK_BITS: result = bits;
         PICK_LESS: result = {{(WIDTH-1){1'b0}}, less};
         default:   result = '0;
      endcase
   end

   assign zero = (pick != PICK_NONE) && (result == '0);
   assign ovf  = arith & sovf;

endmodule

// File: rtl/mfalu_chk.sv
module mfalu_chk
   import mfalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] result,
   input logic             zero,
   input logic             ovf
);

   always_comb begin
      if (op_code == OPC_ADD) begin
         a_r1_add_sum : assert (result == (op_a + op_b))
            else $error("a_r1_add_sum");
      end
      if (op_code == OPC_SUB) begin
         a_r2_sub_diff : assert (result == (op_a - op_b))
            else $error("a_r2_sub_diff");
      end
      if ((op_code == OPC_AND) || (op_code == OPC_OR) ||
          (op_code == OPC_XOR) || (op_code == OPC_NOR)) begin
         a_r3_no_overflow : assert (!ovf)
            else $error("a_r3_no_overflow");
      end
      if (op_code == OPC_SLT) begin
         a_r4_slt_upper : assert (result[WIDTH-1:1] == '0)
            else $error("a_r4_slt_upper");
      end
      if (opc_known(op_code)) begin
         a_r5_zero_flag : assert (zero == (result == '0))
            else $error("a_r5_zero_flag");
      end
      if (!opc_known(op_code)) begin
         a_r7_undef_quiet : assert ((result == '0) && !zero && !ovf)
            else $error("a_r7_undef_quiet");
      end
   end

endmodule

bind mfalu_core mfalu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_mfalu_core.sv
`timescale 1ns/1ps
module sim_mfalu_core;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] op_a;
   logic [W-1:0] op_b;
   logic [3:0]   op_code;
   logic [W-1:0] result;
   logic         zero;
   logic         ovf;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;   // 125 MHz

   mfalu_core #(.WIDTH(W)) u0 (
      .op_a(op_a), .op_b(op_b), .op_code(op_code),
      .result(result), .zero(zero), .ovf(ovf)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // independent reference from the requirements
   task automatic ref_model(input logic [3:0] c, input logic [W-1:0] a,
                            input logic [W-1:0] b, output logic [W-1:0] r,
                            output logic z, output logic v);
      longint sa, sb, t;
      bit defd;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      defd = 1'b1;
      v = 1'b0;
      case (c)
         4'b0000: begin t = sa + sb; r = a + b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
         4'b0010: begin t = sa - sb; r = a - b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
         4'b1010: begin t = sa - sb; r = (sa < sb) ? 32'd1 : 32'd0; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
         4'b0100: r = a & b;
         4'b0101: r = a | b;
         4'b0110: r = a ^ b;
         4'b0111: r = ~(a | b);
         default: begin r = '0; defd = 1'b0; end
      endcase
      z = defd && (r == '0);
   endtask

   // drive on falling edge, check after settling in same half cycle
   task automatic apply(input string tag, input logic [3:0] c,
                        input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] er;
      logic ez, ev;
      @(negedge clk);
      op_code = c; op_a = a; op_b = b;
      #1;
      ref_model(c, a, b, er, ez, ev);
      checks = checks + 1;
      if ((result !== er) || (zero !== ez) || (ovf !== ev)) begin
         errors = errors + 1;
         $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b v=%b exp r=%h z=%b v=%b",
                  tag, c, a, b, result, zero, ovf, er, ez, ev);
      end
   endtask

   task automatic t_idle;
      apply("R5 idle", 4'b0000, 32'h0, 32'h0);
   endtask

   task automatic t_add;
      apply("R1", 4'b0000, 32'd5, 32'd7);
      apply("R1", 4'b0000, 32'h7fff_ffff, 32'h1);
      apply("R1", 4'b0000, 32'h8000_0000, 32'h8000_0000);
      apply("R1", 4'b0000, 32'hffff_ffff, 32'h1);
      apply("R1", 4'b0000, 32'hffff_ffff, 32'hffff_ffff);
      for (int i = 0; i < 40; i++) begin
         seed = next_rand(seed); op_a = seed;
         seed = next_rand(seed);
         apply("R1 rand", 4'b0000, op_a, seed);
      end
   endtask

   task automatic t_sub;
      apply("R2 R5", 4'b0010, 32'hdead_beef, 32'hdead_beef);
      apply("R2", 4'b0010, 32'h8000_0000, 32'h1);
      apply("R2", 4'b0010, 32'h0, 32'h8000_0000);
      apply("R2", 4'b0010, 32'h7fff_ffff, 32'hffff_ffff);
      apply("R2", 4'b0010, 32'h3, 32'h5);
      for (int i = 0; i < 40; i++) begin
         seed = next_rand(seed); op_a = seed;
         seed = next_rand(seed);
         apply("R2 rand", 4'b0010, op_a, seed);
      end
   endtask

   task automatic t_logic;
      for (int c = 4; c < 8; c++) begin
         apply("R3", 4'(c), 32'hf0f0_cc33, 32'h0ff0_5a5a);
         apply("R3 R5", 4'(c), 32'hffff_ffff, 32'h0);
         apply("R3", 4'(c), 32'h8000_0000, 32'h8000_0000);
         for (int i = 0; i < 10; i++) begin
            seed = next_rand(seed); op_a = seed;
            seed = next_rand(seed);
            apply("R3 rand", 4'(c), op_a, seed);
         end
      end
   endtask

   task automatic t_slt;
      apply("R4", 4'b1010, 32'hffff_ffff, 32'h0);
      apply("R4", 4'b1010, 32'h0, 32'hffff_ffff);
      apply("R4 R5", 4'b1010, 32'h1234, 32'h1234);
      apply("R6", 4'b1010, 32'h8000_0000, 32'h7fff_ffff);
      apply("R6", 4'b1010, 32'h7fff_ffff, 32'h8000_0000);
      apply("R6", 4'b1010, 32'h8000_0000, 32'h1);
      for (int i = 0; i < 40; i++) begin
         seed = next_rand(seed); op_a = seed;
         seed = next_rand(seed);
         apply("R4 R6 rand", 4'b1010, op_a, seed);
      end
   endtask

   task automatic t_undef;
      for (int c = 0; c < 16; c++) begin
         if (!(c == 0 || c == 2 || c == 4 || c == 5 || c == 6 || c == 7 || c == 10)) begin
            apply("R7", 4'(c), 32'h7fff_ffff, 32'h1);
            apply("R7", 4'(c), 32'h0, 32'h0);
         end
      end
   endtask

   initial begin
      op_a = '0; op_b = '0; op_code = '0;
      repeat (2) @(posedge clk);
      t_idle;
      t_add;
      t_sub;
      t_logic;
      t_slt;
      t_undef;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule